// File: doc/BRIEF.md
# 64-by-32 Saturating Divider

This block divides a 64-bit dividend by a 32-bit divisor over many clock cycles and returns a 32-bit quotient. The dividend is built from two 32-bit inputs: the high word comes from a Y register value and the low word from the first operand. The divisor is the second operand. A mode select chooses unsigned or two's-complement signed division. When the true quotient does not fit in 32 bits, the block clamps it to a fixed saturation value and raises an overflow flag, which a condition-code stage can use. A zero divisor ends the operation at once with a divide-by-zero indication and no quotient.

The block is used with a start/done handshake. A start pulse is taken only while the block is idle. The operands are converted to magnitudes, divided one quotient bit per cycle by restoring shift-and-subtract, and the sign is applied at the end. The results stay on the outputs until the next operation completes.

Top module: `sat_divider`

## Requirements
- R1: In unsigned mode (`is_signed`=0) the dividend is the 64-bit value {`y_in`,`a_in`} (`y_in` the upper word) and the divisor is `b_in`. When the quotient fits in 32 bits, `quotient` equals floor(dividend / divisor) and `overflow` is 0.
- R2: In signed mode (`is_signed`=1) {`y_in`,`a_in`} and `b_in` are two's-complement values. The quotient is rounded toward zero, so it is negative exactly when the operand signs differ and the magnitude is not zero. When it fits in the signed 32-bit range, `overflow` is 0.
- R3: In unsigned mode a quotient above 0xFFFFFFFF gives `quotient`=0xFFFFFFFF and `overflow`=1.
- R4: In signed mode a quotient above 2^31-1 gives 0x7FFFFFFF and a quotient below -2^31 gives 0x80000000, each with `overflow`=1. A quotient of exactly -2^31 is returned as 0x80000000 with `overflow`=0.
- R5: An accepted start with `b_in`=0 raises `done` on the next cycle with `div_zero`=1, `quotient`=0 and `overflow`=0, and `busy` stays 0. Any completion with a non-zero divisor clears `div_zero`.
- R6: For a non-zero divisor, `done` rises exactly 2W+1 = 65 cycles after the clock edge that accepted `start`, and it lasts for one cycle.
- R7: `busy` is 1 from the cycle after a non-zero-divisor start is accepted up to, but not including, the `done` cycle. A `start` seen while `busy` is 1 is ignored: the running result and its timing do not change.
- R8: After reset all outputs are 0. `quotient`, `overflow` and `div_zero` change only in a cycle in which `done` is 1, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| is_signed | input | 1 | 1 = signed division, 0 = unsigned |
| y_in | input | 32 | Upper word of the dividend |
| a_in | input | 32 | Lower word of the dividend |
| b_in | input | 32 | Divisor |
| quotient | output | 32 | Saturated quotient |
| overflow | output | 1 | Quotient was clamped |
| div_zero | output | 1 | Divisor was zero |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Unsigned cases cover a small exact quotient, a dividend whose high word decides the result, a divisor with its top bit set, and a high word one below the divisor. Together they separate correct use of Y from a division of the low word alone, and show where saturation starts. Signed cases use every sign combination, to check truncation toward zero, and the values around -2^31 and 2^31-1, including division of the most negative dividend by -1. These separate a correct clamp direction from a wrap. Zero divisors are issued one after another, and a start is pulsed during a running division, to check the one-cycle trap path and that starts are ignored while busy.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_operand.sv
module sdiv_operand #(
    parameter int W = 32
) (
    input  logic             is_signed,
    input  logic [W-1:0]     y_in,
    input  logic [W-1:0]     a_in,
    input  logic [W-1:0]     b_in,
    output logic [2*W-1:0]   dvd_mag,
    output logic [W-1:0]     dsr_mag,
    output logic             res_neg,
    output logic             dsr_zero
);
    localparam int DW = 2 * W;

    logic [DW-1:0] dvd_raw;
    logic          neg_n;
    logic          neg_d;

    always_comb begin
        dvd_raw  = {y_in, a_in};
        neg_n    = is_signed & y_in[W-1];
        neg_d    = is_signed & b_in[W-1];
        dvd_mag  = neg_n ? (-dvd_raw) : dvd_raw;
        dsr_mag  = neg_d ? (-b_in) : b_in;
        res_neg  = neg_n ^ neg_d;
        dsr_zero = (b_in == '0);
    end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [2*W-1:0]   dvd_mag,
    input  logic [W-1:0]     dsr_mag,
    output logic             busy,
    output logic             fin,
    output logic [2*W-1:0]   quo_mag
);
    import sdiv_pkg::*;

    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        sdiv_state_e   st;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [DW-1:0] quo;
        logic [W-1:0]  dsr;
    } core_s;

    core_s        core_d, core_q;
    logic [W:0]   shifted;
    logic [W:0]   diff;
    logic         take;

    always_comb begin
        core_d  = core_q;
        shifted = {core_q.rem, core_q.quo[DW-1]};
        diff    = shifted - {1'b0, core_q.dsr};
        take    = ~diff[W];
        case (core_q.st)
            ST_IDLE: begin
                if (load) begin
                    core_d.st  = ST_RUN;
                    core_d.cnt = '0;
                    core_d.rem = '0;
                    core_d.quo = dvd_mag;
                    core_d.dsr = dsr_mag;
                end
            end
            ST_RUN: begin
                core_d.rem = take ? diff[W-1:0] : shifted[W-1:0];
                core_d.quo = {core_q.quo[DW-2:0], take};
                core_d.cnt = core_q.cnt + 1'b1;
                if (core_q.cnt == CW'(DW - 1)) begin
                    core_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                core_d.st = ST_IDLE;
            end
            default: begin
                core_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '{st: ST_IDLE, default: '0};
        end else begin
            core_q <= core_d;
        end
    end

    assign busy    = (core_q.st != ST_IDLE);
    assign fin     = (core_q.st == ST_FIN);
    assign quo_mag = core_q.quo;
endmodule

// File: rtl/sdiv_saturate.sv
module sdiv_saturate #(
    parameter int W = 32
) (
    input  logic             is_signed,
    input  logic             res_neg,
    input  logic [2*W-1:0]   quo_mag,
    output logic [W-1:0]     q_out,
    output logic             ovf
);
    localparam int DW = 2 * W;
    localparam logic [DW-1:0] LIM_NEG = DW'(1) << (W - 1);
    localparam logic [DW-1:0] LIM_POS = LIM_NEG - DW'(1);
    localparam logic [W-1:0]  SAT_NEG = W'(1) << (W - 1);
    localparam logic [W-1:0]  SAT_POS = SAT_NEG - W'(1);

    always_comb begin
        if (!is_signed) begin
            ovf   = |quo_mag[DW-1:W];
            q_out = ovf ? '1 : quo_mag[W-1:0];
        end else if (res_neg) begin
            ovf   = (quo_mag > LIM_NEG);
            q_out = ovf ? SAT_NEG : (-quo_mag[W-1:0]);
        end else begin
            ovf   = (quo_mag > LIM_POS);
            q_out = ovf ? SAT_POS : quo_mag[W-1:0];
        end
    end
endmodule

// File: rtl/sat_divider.sv
module sat_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] quotient,
    output logic         overflow,
    output logic         div_zero,
    output logic         busy,
    output logic         done
);
    localparam int DW = 2 * W;

    typedef struct packed {
        logic [W-1:0] q;
        logic         ovf;
        logic         dz;
        logic         done;
        logic         neg;
        logic         sgn;
    } res_s;

    res_s          res_d, res_q;
    logic [DW-1:0] dvd_mag;
    logic [W-1:0]  dsr_mag;
    logic          res_neg;
    logic          dsr_zero;
    logic          core_busy;
    logic          core_fin;
    logic [DW-1:0] quo_mag;
    logic [W-1:0]  sat_q;
    logic          sat_ovf;
    logic          accept;
    logic          load;

    sdiv_operand #(.W(W)) u_operand (
        .is_signed (is_signed),
        .y_in      (y_in),
        .a_in      (a_in),
        .b_in      (b_in),
        .dvd_mag   (dvd_mag),
        .dsr_mag   (dsr_mag),
        .res_neg   (res_neg),
        .dsr_zero  (dsr_zero)
    );

    sdiv_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .dvd_mag (dvd_mag),
        .dsr_mag (dsr_mag),
        .busy    (core_busy),
        .fin     (core_fin),
        .quo_mag (quo_mag)
    );

    sdiv_saturate #(.W(W)) u_saturate (
        .is_signed (res_q.sgn),
        .res_neg   (res_q.neg),
        .quo_mag   (quo_mag),
        .q_out     (sat_q),
        .ovf       (sat_ovf)
    );

    assign accept = start & ~core_busy;
    assign load   = accept & ~dsr_zero;

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        if (accept) begin
            res_d.neg = res_neg;
            res_d.sgn = is_signed;
            if (dsr_zero) begin
                res_d.q    = '0;
                res_d.ovf  = 1'b0;
                res_d.dz   = 1'b1;
                res_d.done = 1'b1;
            end
        end
        if (core_fin) begin
            res_d.q    = sat_q;
            res_d.ovf  = sat_ovf;
            res_d.dz   = 1'b0;
            res_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign quotient = res_q.q;
    assign overflow = res_q.ovf;
    assign div_zero = res_q.dz;
    assign done     = res_q.done;
    assign busy     = core_busy;
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] quotient,
    input logic         overflow,
    input logic         div_zero,
    input logic         busy,
    input logic         done
);
    localparam int LAT = 2 * W + 1;
    localparam int BW  = $clog2(LAT + 2);
    localparam logic [W-1:0] SAT_NEG = W'(1) << (W - 1);
    localparam logic [W-1:0] SAT_POS = SAT_NEG - W'(1);

    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= '0;
        end else if (busy) begin
            bcnt <= bcnt + 1'b1;
        end else begin
            bcnt <= '0;
        end
    end

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(busy)) |-> (bcnt == BW'(LAT)));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R5
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (quotient == '0 && !overflow));

    // R3 R4
    saturation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (quotient == '1 || quotient == SAT_POS || quotient == SAT_NEG));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(overflow) && $stable(div_zero)));
endmodule

bind sat_divider sdiv_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .quotient (quotient),
    .overflow (overflow),
    .div_zero (div_zero),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_sat_divider.sv
module tb_sat_divider;
    localparam int W   = 32;
    localparam int LAT = 2 * W + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] y_in = '0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] quotient;
    logic         overflow;
    logic         div_zero;
    logic         busy;
    logic         done;

    int n_chk = 0;
    int n_fail = 0;
    logic ena = 1'b0;

    int           m_cnt = 0;
    logic         m_done = 1'b0;
    logic [W-1:0] m_q = '0;
    logic         m_ov = 1'b0;
    logic         m_dz = 1'b0;
    logic [W-1:0] pend_q = '0;
    logic         pend_ov = 1'b0;
    string        m_tag = "R8";
    string        pend_tag = "R1";
    string        cur_tag = "R1";

    always #2 clk = ~clk;

    sat_divider #(.W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_signed (is_signed),
        .y_in      (y_in),
        .a_in      (a_in),
        .b_in      (b_in),
        .quotient  (quotient),
        .overflow  (overflow),
        .div_zero  (div_zero),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic ref_div(input logic sg, input logic [W-1:0] y, input logic [W-1:0] a,
                           input logic [W-1:0] b, output logic [W-1:0] q, output logic ov);
        logic signed [127:0] n;
        logic signed [127:0] d;
        logic signed [127:0] r;
        if (sg) begin
            n = $signed({y, a});
            d = $signed(b);
        end else begin
            n = {64'd0, y, a};
            d = {96'd0, b};
        end
        r = n / d;
        ov = 1'b0;
        q = r[W-1:0];
        if (sg) begin
            if (r > 128'sh7FFFFFFF) begin
                ov = 1'b1; q = 32'h7FFFFFFF;
            end else if (r < -128'sh80000000) begin
                ov = 1'b1; q = 32'h80000000;
            end
        end else if (r > 128'shFFFFFFFF) begin
            ov = 1'b1; q = 32'hFFFFFFFF;
        end
    endtask

    // Behavioural reference: latency counter plus pending result.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 1'b0; m_q = '0; m_ov = 1'b0; m_dz = 1'b0;
        end else begin
            m_done = 1'b0;
            if (m_cnt != 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1'b1; m_q = pend_q; m_ov = pend_ov; m_dz = 1'b0; m_tag = pend_tag;
                end
            end else if (start) begin
                if (b_in == '0) begin
                    m_done = 1'b1; m_q = '0; m_ov = 1'b0; m_dz = 1'b1; m_tag = cur_tag;
                end else begin
                    ref_div(is_signed, y_in, a_in, b_in, pend_q, pend_ov);
                    pend_tag = cur_tag;
                    m_cnt = LAT;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && ena) begin
            chk(busy === (m_cnt != 0), "R7", "busy", {31'd0, busy}, {31'd0, m_cnt != 0});
            chk(done === m_done, "R6", "done", {31'd0, done}, {31'd0, m_done});
            if (m_done) begin
                chk(quotient === m_q, m_tag, "quotient", quotient, m_q);
                chk(overflow === m_ov, m_tag, "overflow", {31'd0, overflow}, {31'd0, m_ov});
                chk(div_zero === m_dz, m_tag, "div_zero", {31'd0, div_zero}, {31'd0, m_dz});
            end else begin
                chk(quotient === m_q, "R8", "held quotient", quotient, m_q);
                chk(overflow === m_ov && div_zero === m_dz, "R8", "held flags",
                    {30'd0, overflow, div_zero}, {30'd0, m_ov, m_dz});
            end
        end
    end

    task automatic op(input logic sg, input logic [W-1:0] y, input logic [W-1:0] a,
                      input logic [W-1:0] b, input string tag);
        cur_tag = tag;
        is_signed = sg; y_in = y; a_in = a; b_in = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_cnt != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(quotient === '0, "R8", "reset quotient", quotient, '0);
        chk({overflow, div_zero, busy, done} === 4'b0, "R8", "reset flags",
            {28'd0, overflow, div_zero, busy, done}, '0);
        rst_n = 1'b1;
        ena = 1'b1;
        @(negedge clk);

        op(1'b0, 32'h0, 32'd100, 32'd7, "R1");
        op(1'b0, 32'h1, 32'h0, 32'd2, "R1");
        op(1'b0, 32'h12345678, 32'h9ABCDEF0, 32'h23456789, "R1");
        op(1'b0, 32'hFFFFFFFE, 32'h0, 32'hFFFFFFFF, "R1");
        op(1'b0, 32'h2, 32'hFFFFFFFF, 32'd3, "R1");
        op(1'b0, 32'h5, 32'h0, 32'd3, "R3");
        op(1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd1, "R3");
        op(1'b0, 32'h3, 32'h0, 32'd3, "R3");

        op(1'b1, 32'hFFFFFFFF, -32'sd7, 32'd2, "R2");
        op(1'b1, 32'h0, 32'd7, -32'sd2, "R2");
        op(1'b1, 32'hFFFFFFFF, -32'sd7, -32'sd2, "R2");
        op(1'b1, 32'h0, 32'd1, -32'sd5, "R2");
        op(1'b1, 32'h0, 32'h80000000, 32'd1, "R4");
        op(1'b1, 32'hFFFFFFFF, 32'h80000000, 32'd1, "R4");
        op(1'b1, 32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFFF, "R4");
        op(1'b1, 32'h80000000, 32'h0, 32'hFFFFFFFF, "R4");
        op(1'b1, 32'h1, 32'h0, 32'hFFFFFFFF, "R4");
        op(1'b1, 32'h0, 32'h7FFFFFFF, 32'd1, "R4");

        op(1'b0, 32'h1, 32'h2, 32'h0, "R5");
        op(1'b1, 32'hFFFFFFFF, 32'h2, 32'h0, "R5");

        // Two zero-divisor starts on consecutive cycles, then a real divide.
        cur_tag = "R5";
        is_signed = 1'b0; y_in = 32'h0; a_in = 32'd9; b_in = '0; start = 1'b1;
        @(negedge clk);
        y_in = 32'h7; b_in = '0;
        @(negedge clk);
        cur_tag = "R7";
        y_in = 32'h0; a_in = 32'd1000; b_in = 32'd10;
        @(negedge clk);
        start = 1'b0;
        // Starts during the run must be ignored.
        repeat (10) @(negedge clk);
        cur_tag = "R7 ignored";
        y_in = 32'h1; a_in = 32'h0; b_in = 32'd0; start = 1'b1;
        @(negedge clk);
        b_in = 32'd3;
        repeat (5) @(negedge clk);
        start = 1'b0;
        while (m_cnt != 0) @(negedge clk);
        repeat (3) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule